// File: doc/BRIEF.md
# Iterative Integer Multiplier with Overflow Detection

This block is a multi-cycle 64-bit integer multiplier for the execute stage of a RISC core. The core raises a start strobe with a 7-bit function code and two 64-bit operands. The unit runs a shift-and-add loop over the multiplier bits, retiring a parameterizable number of bits per cycle (one or two). When the loop ends, it forms the requested result and raises a one-cycle done strobe. Only one operation is in flight at a time. A start that arrives while the unit is busy has no effect.

Five operations are provided:
- a longword multiply that returns the 32-bit signed product sign-extended to 64 bits;
- a quadword multiply that returns the low 64 bits of the product;
- an unsigned multiply-high that returns the upper 64 bits of the 128-bit unsigned product;
- overflow-checking versions of the longword and quadword multiplies.

The overflow check asks whether the bits that are thrown away all equal the sign bit that is kept. For the quadword form, the signed 128-bit product is recovered from the unsigned loop result. The correction subtracts B from the upper half when A is negative, and subtracts A when B is negative.

Top module: `iter_mul`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, busy_o, done_o and ovf_o are 0 and result_o is zero.
- R2: A start is taken only while busy_o is 0. After a start is taken, busy_o is 1 until the cycle in which done_o is 1. done_o is high for exactly one cycle, and busy_o is 0 during that cycle.
- R3: If start_i is taken at rising edge k, done_o is 1 after rising edge k + 64/STEP + 1. With the default STEP of 2, that is 33 edges later.
- R4: A start_i pulse while busy_o is 1 is ignored. busy_o stays 1, no extra done_o pulse occurs, and the result of the running operation is unchanged.
- R5: result_o and ovf_o hold their values from the done cycle until the next start is taken.
- R6: Function 0x00 multiplies the sign-extended low 32 bits of both operands. It returns bits 31:0 of the product sign-extended to 64 bits.
- R7: Function 0x20 returns bits 63:0 of the product.
- R8: Function 0x30 returns bits 127:64 of the unsigned 128-bit product.
- R9: Function 0x40 returns the same result as 0x00. It sets ovf_o unless bits 63:31 of the 64-bit signed product of the sign-extended low words are all 0 or all 1.
- R10: Function 0x60 returns the same result as 0x20. It sets ovf_o unless either (a) the upper 64 bits of the signed 128-bit product are all 0 and bit 63 of the result is 0, or (b) the upper 64 bits are all 1 and bit 63 of the result is 1.
- R11: For functions 0x00, 0x20 and 0x30, ovf_o is 0 at done.
- R12: Any other function code completes with the same timing and returns result_o = 0 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when not busy |
| func_i | input | 7 | Function code |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 64 | Result, held until next start |
| ovf_o | output | 1 | Overflow flag, held until next start |

## Verification
The embedded assertions check the following on every cycle:
- the handshake: done_o is never high together with busy_o, done_o is a single-cycle pulse, and result_o stays stable while busy;
- the step counter stays in range;
- a start during the loop never ends the busy period;
- the overflow flag is clear for the non-checking functions.

Numerical correctness can only be shown by the bench scenarios, which compare against an independent 128-bit reference model. These scenarios include the exact latency, the boundaries of the overflow rule (products of exactly ±2^31 and ±2^63), the all-ones multiply-high case, and the rejection of unknown function codes.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam logic [6:0] FN_MULL  = 7'h00;
  localparam logic [6:0] FN_MULQ  = 7'h20;
  localparam logic [6:0] FN_UMULH = 7'h30;
  localparam logic [6:0] FN_MULLV = 7'h40;
  localparam logic [6:0] FN_MULQV = 7'h60;

  typedef enum logic [2:0] {
    K_MULL, K_MULQ, K_UMULH, K_MULLV, K_MULQV, K_NONE
  } mul_kind_e;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} mul_state_e;
endpackage

// File: rtl/imul_decode.sv
module imul_decode
  import imul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [6:0]      func_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output mul_kind_e       kind_o,
  output logic [XLEN-1:0] op_a_o,
  output logic [XLEN-1:0] op_b_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic long_form;

  always_comb begin
    unique case (func_i)
      FN_MULL:  kind_o = K_MULL;
      FN_MULQ:  kind_o = K_MULQ;
      FN_UMULH: kind_o = K_UMULH;
      FN_MULLV: kind_o = K_MULLV;
      FN_MULQV: kind_o = K_MULQV;
      default:  kind_o = K_NONE;
    endcase
  end

  assign long_form = (kind_o == K_MULL) || (kind_o == K_MULLV);

  // longword forms see only the sign-extended low halves
  assign op_a_o = long_form ? {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]} : a_i;
  assign op_b_o = long_form ? {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]} : b_i;
endmodule

// File: rtl/imul_core.sv
module imul_core #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned STEP = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            run_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            last_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  localparam int unsigned NSTEPS = XLEN / STEP;
  localparam int unsigned CW     = $clog2(NSTEPS) + 1;
  localparam logic [CW-1:0] LAST = CW'(NSTEPS - 1);

  logic [XLEN-1:0] mcand_q, hi_q, lo_q;
  logic [CW-1:0]   cnt_q;

  logic [XLEN-1:0] hi_s [STEP+1];
  logic [XLEN-1:0] lo_s [STEP+1];

  assign hi_s[0] = hi_q;
  assign lo_s[0] = lo_q;

  // STEP chained add-and-shift stages per cycle
  for (genvar g = 0; g < STEP; g++) begin : g_stage
    logic [XLEN:0] sum;
    assign sum = {1'b0, hi_s[g]} + (lo_s[g][0] ? {1'b0, mcand_q} : '0);
    assign hi_s[g+1] = sum[XLEN:1];
    assign lo_s[g+1] = {sum[0], lo_s[g][XLEN-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      hi_q    <= '0;
      lo_q    <= b_i;
      cnt_q   <= '0;
    end else if (run_i) begin
      hi_q  <= hi_s[STEP];
      lo_q  <= lo_s[STEP];
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = run_i && (cnt_q == LAST);
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= LAST));

  // R2
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_i);
endmodule

// File: rtl/imul_finish.sv
module imul_finish
  import imul_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  mul_kind_e       kind_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] hi_signed;
  logic [HALF:0]   long_top;
  logic [XLEN-1:0] long_res;
  logic            long_ovf, quad_ovf;

  // unsigned-to-signed correction of the upper half
  assign hi_signed = hi_i - (op_a_i[XLEN-1] ? op_b_i : '0)
                          - (op_b_i[XLEN-1] ? op_a_i : '0);

  assign long_top = lo_i[XLEN-1:HALF-1];
  assign long_ovf = (long_top != '0) && (long_top != '1);
  assign quad_ovf = !(((hi_signed == '0) && !lo_i[XLEN-1]) ||
                      ((hi_signed == '1) &&  lo_i[XLEN-1]));
  assign long_res = {{HALF{lo_i[HALF-1]}}, lo_i[HALF-1:0]};

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (kind_i)
      K_MULL:  result_o = long_res;
      K_MULLV: begin result_o = long_res; ovf_o = long_ovf; end
      K_MULQ:  result_o = lo_i;
      K_MULQV: begin result_o = lo_i; ovf_o = quad_ovf; end
      K_UMULH: result_o = hi_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/iter_mul.sv
module iter_mul
  import imul_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned STEP = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [6:0]      func_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o,
  output logic            ovf_o
);
  mul_state_e      state_q;
  mul_kind_e       kind_d, kind_q;
  logic [XLEN-1:0] op_a_d, op_b_d, op_a_q, op_b_q;
  logic [XLEN-1:0] prod_hi, prod_lo, fin_res;
  logic            fin_ovf, last, accept;
  logic            done_q, ovf_q;
  logic [XLEN-1:0] result_q;

  assign accept = (state_q == S_IDLE) && start_i;

  imul_decode #(.XLEN(XLEN)) u_dec (
    .func_i (func_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .kind_o (kind_d),
    .op_a_o (op_a_d),
    .op_b_o (op_b_d)
  );

  imul_core #(.XLEN(XLEN), .STEP(STEP)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .run_i  (state_q == S_RUN),
    .a_i    (op_a_d),
    .b_i    (op_b_d),
    .last_o (last),
    .hi_o   (prod_hi),
    .lo_o   (prod_lo)
  );

  imul_finish #(.XLEN(XLEN)) u_fin (
    .kind_i   (kind_q),
    .op_a_i   (op_a_q),
    .op_b_i   (op_b_q),
    .hi_i     (prod_hi),
    .lo_i     (prod_lo),
    .result_o (fin_res),
    .ovf_o    (fin_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      kind_q   <= K_NONE;
      op_a_q   <= '0;
      op_b_q   <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_RUN;
          kind_q  <= kind_d;
          op_a_q  <= op_a_d;
          op_b_q  <= op_b_d;
        end
        S_RUN: if (last) state_q <= S_FIN;
        S_FIN: begin
          state_q  <= S_IDLE;
          result_q <= fin_res;
          ovf_q    <= fin_ovf;
          done_q   <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign ovf_o    = ovf_q;

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(result_o) && $stable(ovf_o)));

  // R4
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN) && start_i |=> busy_o);

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (kind_q != K_MULLV) && (kind_q != K_MULQV) |-> !ovf_o);
endmodule

// File: tb/iter_mul_tb_top.sv
module iter_mul_tb_top;
  localparam int STEP = 2;
  localparam int LAT  = 64 / STEP + 1;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    int          t0;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  func_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [63:0] result_o;

  int tests = 0, fails = 0, cyc = 0;
  exp_t exp_q[$];
  logic [63:0] last_res;
  logic        last_ovf;

  iter_mul #(.XLEN(64), .STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .func_i(func_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  always #5 clk = ~clk;

  function automatic void model(input logic [6:0] f, input logic [63:0] a, b,
                                output logic [63:0] r, output logic o);
    logic signed [63:0]  a32, b32, p32;
    logic signed [127:0] ps;
    logic [127:0]        pu;
    r = '0; o = 1'b0;
    case (f)
      7'h00, 7'h40: begin
        a32 = {{32{a[31]}}, a[31:0]};
        b32 = {{32{b[31]}}, b[31:0]};
        p32 = a32 * b32;
        r = {{32{p32[31]}}, p32[31:0]};
        o = (f == 7'h40) && !((p32[63:31] == '0) || (p32[63:31] == '1));
      end
      7'h20, 7'h60: begin
        ps = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        r = ps[63:0];
        o = (f == 7'h60) && !(((ps[127:64] == '0) && !ps[63]) ||
                              ((ps[127:64] == '1) && ps[63]));
      end
      7'h30: begin
        pu = {64'b0, a} * {64'b0, b};
        r = pu[127:64];
      end
      default: ;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: start one operation and push its expectation
  task automatic issue(input logic [6:0] f, input logic [63:0] a, b, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    model(f, a, b, e.res, e.ovf);
    e.t0 = cyc + 1;
    e.tag = tag;
    exp_q.push_back(e);
    func_i = f; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || busy_o) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: pop and compare on each done strobe
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4: actual unexpected done expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " result"}, result_o, e.res);
        check({e.tag, " ovf"}, 64'(ovf_o), 64'(e.ovf));
        check("R3 latency", 64'(cyc - e.t0), 64'(LAT));
        check("R2 busy low at done", 64'(busy_o), 64'd0);
        last_res = result_o;
        last_ovf = ovf_o;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 busy", 64'(busy_o), 0);
    check("R1 done", 64'(done_o), 0);
    check("R1 ovf",  64'(ovf_o), 0);
    check("R1 result", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after release", result_o, 0);

    // R6 longword, garbage in high words
    issue(7'h00, 64'hDEAD_BEEF_0000_0007, 64'h1234_5678_FFFF_FFFD, "R6");
    issue(7'h00, 64'h0000_0000_7FFF_FFFF, 64'h2, "R6 wrap R11");
    // R7 quadword low
    issue(7'h20, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R7");
    issue(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R7 R11");
    // R8 unsigned high
    issue(7'h30, '1, '1, "R8 all ones");
    issue(7'h30, 64'h8000_0000_0000_0000, 64'h2, "R8");
    issue(7'h30, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R8 R11");
    // R9 longword overflow edges
    issue(7'h40, 64'h1_0000, 64'h1_0000, "R9 2^32");
    issue(7'h40, 64'h8000, 64'hFFFF_FFFF_FFFF_0000, "R9 -2^31");
    issue(7'h40, 64'h8000_0000, 64'hFFFF_FFFF, "R9 +2^31");
    issue(7'h40, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_4321, "R9 fits");
    // R10 quadword overflow edges
    issue(7'h60, 64'h1_0000_0000, 64'h8000_0000, "R10 +2^63");
    issue(7'h60, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000, "R10 -2^63");
    issue(7'h60, '1, '1, "R10 -1*-1");
    issue(7'h60, 64'h8000_0000_0000_0000, '1, "R10 min*-1");
    issue(7'h60, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R10 big");
    // R12 unknown codes
    issue(7'h13, 64'h55, 64'h77, "R12");
    issue(7'h7F, '1, '1, "R12");
    drain();

    // R4 start pulses while busy
    issue(7'h20, 64'd11, 64'd13, "R4 first");
    for (int i = 0; i < 3; i++) begin
      func_i = 7'h30; a_i = '1; b_i = '1; start_i = 1'b1;
      @(negedge clk);
      check("R4 busy held", 64'(busy_o), 64'd1);
    end
    start_i = 1'b0;
    drain();

    // R5 hold after done
    issue(7'h60, 64'h8000_0000_0000_0000, '1, "R5 setup");
    drain();
    func_i = 7'h00; a_i = '0; b_i = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R5 result hold", result_o, last_res);
      check("R5 ovf hold", 64'(ovf_o), 64'(last_ovf));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule